// File: doc/BRIEF.md
# Synchronous Burst Flash Read Engine

This block fetches a run of consecutive words from a synchronous parallel NOR flash that supports burst reads. A requester presents a start address and a word count with a one-cycle start pulse. The engine then enables the flash, latches the start address with a single active-low address-valid strobe, and toggles a flash clock derived from the system clock. After the strobe, every rising flash-clock edge advances the flash's own address counter, so the address bus keeps the start address for the whole burst. Once a configurable initial latency has passed, the engine captures one word per flash clock and passes it on as a valid/ready stream.

The flash clock runs at half the system clock when one device is attached and at a quarter when two devices work as a pair. The stream follows these back-pressure rules. A word, once offered, stays on the output with valid high until ready is seen. The output holds one word. If that word is still unaccepted when the next capture is due, the engine freezes the flash clock in its high phase. No further edges reach the flash until the word is taken, so no data is lost and the flash's internal counter does not run ahead.

Top module: `bflash_rdr`

## Requirements
- R1: While reset is low and after reset is released with no start, chip enable, output enable, write enable and address-valid are high, the flash clock and `m_valid_o` are low, and `busy_o` is low. The flash reset output is low during reset and high after it.
- R2: During a burst the flash clock spends DIV/2 system cycles low before each rising edge. DIV is 2 when `DUAL_DEV` is 0 and 4 when it is 1. Between bursts the flash clock stays low.
- R3: A start pulse is taken only when `busy_o` is low and the length is nonzero. A start during a burst, or with length 0, leaves the address bus, the strobe count and the word stream unchanged.
- R4: Each burst drives address-valid low for exactly one flash-clock period, and that period contains the first rising edge. The start address is on the address bus at that edge. The address bus does not change for the rest of the burst.
- R5: The first word appears on the stream (LAT_CLKS+1)*DIV system cycles after the edge that takes the start, for any LAT_CLKS of 1 or more.
- R6: Word i of the stream is the flash data present during the period that begins with rising edge LAT_CLKS+i, counted from the strobe edge as edge 0. Exactly the requested number of words is delivered. The flash sees LAT_CLKS+length rising edges per burst.
- R7: While `m_valid_o` is high and `m_ready_i` is low, valid stays high and the data stays unchanged. The flash clock stops until the word is taken, and no word is dropped or repeated.
- R8: Write enable stays high at all times. Chip enable and output enable return high together after the last word is captured.
- R9: The data path is `DATA_W` bits wide, either 8 or 16, and the full word is carried unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle request to begin a burst |
| start_addr_i | input | ADDR_W | Flash word address of the first word |
| burst_len_i | input | LEN_W | Number of words to read |
| busy_o | output | 1 | High while a burst is running |
| fl_clk_o | output | 1 | Divided flash clock |
| fl_nce_o | output | 1 | Flash chip enable, active low |
| fl_noe_o | output | 1 | Flash output enable, active low |
| fl_nwe_o | output | 1 | Flash write enable, active low, held high |
| fl_nadv_o | output | 1 | Address-valid strobe, active low |
| fl_nrst_o | output | 1 | Flash reset, active low |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_i | input | DATA_W | Flash data bus |
| m_valid_o | output | 1 | Stream word valid |
| m_data_o | output | DATA_W | Stream word |
| m_ready_i | input | 1 | Stream consumer ready |

## Verification
Two instances run side by side. One has one device, 16-bit data and a latency of three. The other has a device pair, 8-bit data and a latency of one. Each receives every length from 1 to 15 at three start addresses, one of them near the top of the address space so that the flash counter wraps. Every such burst is run under three ready patterns. With ready always high, the bursts show the unstalled flash-clock rhythm and the first-word delay. An alternating pattern and an irregular pattern force stalls at different points of the flash-clock phase, which separates a frozen clock from a dropped or duplicated word. A start during a burst and a zero-length start show whether requests are correctly refused.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_DATA = 2'd3
  } bfr_state_e;

endpackage

// File: rtl/bfr_clkgen.sv
// Phase counter producing the divided flash clock and a period-end strobe.
// The clock is the counter MSB, so DIV must be a power of two (2 or 4).
module bfr_clkgen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic stall_req_i,
  output logic fclk_o,
  output logic per_end_o
);
  localparam int unsigned PH_W = $clog2(DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q;
  logic            at_last;

  assign at_last   = (ph_q == PH_LAST);
  assign per_end_o = en_i && at_last && !stall_req_i;
  assign fclk_o    = ph_q[PH_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (!en_i) begin
      ph_q <= '0;
    end else if (!(at_last && stall_req_i)) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // R7
  frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && at_last && stall_req_i) |=> fclk_o);

endmodule

// File: rtl/bfr_seq.sv
// Burst sequencer: address strobe period, latency wait, data capture periods.
module bfr_seq
  import bfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              per_end_i,
  input  logic              can_load_i,
  output bfr_state_e        state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cap_o,
  output logic              stall_req_o,
  output logic              busy_o
);
  bfr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  words_q;
  logic              wait_done;
  logic              last_word;
  logic              accept;

  generate
    if (LAT > 1) begin : g_wait
      localparam int unsigned WC_W = (LAT > 2) ? $clog2(LAT) : 1;
      localparam logic [WC_W-1:0] WC_LAST = WC_W'(LAT - 2);
      logic [WC_W-1:0] wcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wcnt_q <= '0;
        end else if (state_q != ST_WAIT) begin
          wcnt_q <= '0;
        end else if (per_end_i) begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
      assign wait_done = (wcnt_q == WC_LAST);
    end else begin : g_nowait
      assign wait_done = 1'b1;
    end
  endgenerate

  assign accept      = (state_q == ST_IDLE) && start_i && (len_i != '0);
  assign cap_o       = (state_q == ST_DATA) && per_end_i;
  assign stall_req_o = (state_q == ST_DATA) && !can_load_i;
  assign last_word   = (words_q == len_q - 1'b1);
  assign busy_o      = (state_q != ST_IDLE);
  assign state_o     = state_q;
  assign addr_o      = addr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: if (per_end_i) state_d = (LAT > 1) ? ST_WAIT : ST_DATA;
      ST_WAIT: if (per_end_i && wait_done) state_d = ST_DATA;
      ST_DATA: if (cap_o && last_word) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      words_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= addr_i;
        len_q   <= len_i;
        words_q <= '0;
      end else if (cap_o) begin
        words_q <= words_q + 1'b1;
      end
    end
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(len_q) && $stable(addr_q)));

  // R6
  word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (words_q < len_q));

endmodule

// File: rtl/bfr_outbuf.sv
// One-word output register on the valid/ready stream.
module bfr_outbuf #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              can_load_o,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              m_ready_i
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign can_load_o = !valid_q || m_ready_i;
  assign m_valid_o  = valid_q;
  assign m_data_o   = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (m_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> can_load_o);

endmodule

// File: rtl/bflash_rdr.sv
module bflash_rdr
  import bfr_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LEN_W    = 8,
  parameter bit          DUAL_DEV = 1'b0,
  parameter int unsigned LAT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  output logic              busy_o,
  output logic              fl_clk_o,
  output logic              fl_nce_o,
  output logic              fl_noe_o,
  output logic              fl_nwe_o,
  output logic              fl_nadv_o,
  output logic              fl_nrst_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic [DATA_W-1:0] fl_dq_i,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              m_ready_i
);
  localparam int unsigned DIV = DUAL_DEV ? 4 : 2;

  bfr_state_e state;
  logic       per_end;
  logic       cap;
  logic       stall_req;
  logic       can_load;
  logic       nrst_q;

  bfr_seq #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .LAT    (LAT_CLKS)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (start_addr_i),
    .len_i       (burst_len_i),
    .per_end_i   (per_end),
    .can_load_i  (can_load),
    .state_o     (state),
    .addr_o      (fl_addr_o),
    .cap_o       (cap),
    .stall_req_o (stall_req),
    .busy_o      (busy_o)
  );

  bfr_clkgen #(
    .DIV (DIV)
  ) clkgen_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (busy_o),
    .stall_req_i (stall_req),
    .fclk_o      (fl_clk_o),
    .per_end_o   (per_end)
  );

  bfr_outbuf #(
    .DATA_W (DATA_W)
  ) outbuf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cap),
    .data_i     (fl_dq_i),
    .can_load_o (can_load),
    .m_valid_o  (m_valid_o),
    .m_data_o   (m_data_o),
    .m_ready_i  (m_ready_i)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nrst_q <= 1'b0;
    else        nrst_q <= 1'b1;
  end

  assign fl_nrst_o = nrst_q;
  assign fl_nwe_o  = 1'b1;
  assign fl_nce_o  = (state == ST_IDLE);
  assign fl_nadv_o = (state != ST_ADDR);
  assign fl_noe_o  = !((state == ST_WAIT) || (state == ST_DATA));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_nce_o && $past(!fl_nce_o)) |-> $stable(fl_addr_o));

  // R4
  strobe_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_nadv_o |-> !fl_nce_o);

  // R2
  fclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_clk_o) |-> !fl_nce_o);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_nce_o) |-> (fl_noe_o && fl_nadv_o));

endmodule

// File: tb/bflash_rdr_tb_top.sv
`timescale 1ns/1ps

package bflash_rdr_tb_pkg;
  function automatic logic [15:0] word_at(input logic [31:0] a);
    logic [31:0] m;
    m = a * 32'd40503 + 32'd7919;
    return m[23:8] ^ a[15:0];
  endfunction
endpackage

// Behavioural burst flash: latches the address on a strobed rising edge,
// then advances its own counter on every further rising edge.
module bflash_rdr_flash_model
  import bflash_rdr_tb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int LAT    = 3
) (
  input  logic              fclk,
  input  logic              nce,
  input  logic              noe,
  input  logic              nadv,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq,
  output int                edge_idx,
  output int                strobe_cnt
);
  logic [ADDR_W-1:0] base = '0;
  int                eidx = 0;
  int                scnt = 0;
  logic [ADDR_W-1:0] rd_addr;

  always @(posedge fclk) begin
    if (!nce) begin
      if (!nadv) begin
        base <= addr;
        eidx <= 0;
        scnt <= scnt + 1;
      end else begin
        eidx <= eidx + 1;
      end
    end
  end

  assign rd_addr    = base + ADDR_W'(eidx - LAT);
  assign dq         = (!nce && !noe && eidx >= LAT) ? DATA_W'(word_at(32'(rd_addr)))
                                                    : {DATA_W{1'b1}};
  assign edge_idx   = eidx;
  assign strobe_cnt = scnt;
endmodule

module bflash_rdr_monitor
  import bflash_rdr_tb_pkg::*;
#(
  parameter int    DATA_W = 16,
  parameter int    ADDR_W = 12,
  parameter int    LEN_W  = 4,
  parameter int    DIV    = 2,
  parameter int    LAT    = 3,
  parameter string NAME   = "lane"
) (
  input logic              clk,
  input logic              start,
  input logic [ADDR_W-1:0] addr,
  input logic [LEN_W-1:0]  len,
  input logic              busy,
  input logic              fclk,
  input logic              nce,
  input logic              noe,
  input logic              nwe,
  input logic              nadv,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input int                edge_idx,
  input int                strobe_cnt
);
  int                n_cmp = 0;
  int                n_bad = 0;
  bit                armed = 0;
  bit                done = 1;
  bit                seen = 0;
  bit                prev_fclk = 0;
  bit                nwe_bad = 0;
  int                cnt = 0;
  int                idx = 0;
  int                lowrun = 0;
  int                strobe_at = 0;
  int                blen = 0;
  logic [ADDR_W-1:0] base = '0;
  logic [DATA_W-1:0] exp_w;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", NAME, req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cnt++;
    if (armed) begin
      if (fclk && !prev_fclk && !nce)
        chk(lowrun == DIV / 2, "R2 low phase length", lowrun, DIV / 2);
      if (cnt == 0) lowrun = fclk ? 0 : 1;
      else          lowrun = fclk ? 0 : lowrun + 1;
      if (!nwe) nwe_bad = 1;
      if (m_valid && !seen && !done) begin
        seen = 1;
        chk(cnt == (LAT + 1) * DIV, "R5 first word delay", cnt, (LAT + 1) * DIV);
      end
      if (m_valid && m_ready) begin
        exp_w = DATA_W'(word_at(32'(ADDR_W'(base + ADDR_W'(idx)))));
        chk(m_data == exp_w, "R6 R7 R9 word value", int'(m_data), int'(exp_w));
        idx++;
      end
      if (!done && cnt > 0 && !busy && !m_valid) begin
        done = 1;
        chk(idx == blen, "R6 word count", idx, blen);
        chk(edge_idx == LAT + blen - 1, "R6 flash edge count", edge_idx, LAT + blen - 1);
        chk(strobe_cnt == strobe_at + 1, "R4 single strobe", strobe_cnt, strobe_at + 1);
        chk(nce && noe && nadv && !fclk, "R8 pins released", {nce, noe, nadv, fclk}, 4'b1110);
        chk(!nwe_bad, "R8 write enable high", int'(nwe_bad), 0);
      end
    end
    prev_fclk = fclk;
    if (start && !busy && len != '0) begin
      armed = 1; done = 0; seen = 0; cnt = -1; idx = 0;
      base = addr; blen = int'(len); strobe_at = strobe_cnt; nwe_bad = 0;
    end
  end
endmodule

module bflash_rdr_tb_top;
  localparam int AW = 12;
  localparam int BW = 10;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic          ready = 1'b1;
  int            mode = 0;
  int            cyc = 0;
  int            t_cmp = 0;
  int            t_bad = 0;

  always #2.5 clk = ~clk;

  logic          a_busy, a_fclk, a_nce, a_noe, a_nwe, a_nadv, a_nrst, a_valid;
  logic [AW-1:0] a_addr;
  logic [15:0]   a_dq, a_data;
  int            a_edge, a_strobe;
  logic          b_busy, b_fclk, b_nce, b_noe, b_nwe, b_nadv, b_nrst, b_valid;
  logic [BW-1:0] b_addr;
  logic [7:0]    b_dq, b_data;
  int            b_edge, b_strobe;

  bflash_rdr #(.DATA_W(16), .ADDR_W(AW), .LEN_W(LW), .DUAL_DEV(1'b0), .LAT_CLKS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(addr), .burst_len_i(len),
    .busy_o(a_busy), .fl_clk_o(a_fclk), .fl_nce_o(a_nce), .fl_noe_o(a_noe), .fl_nwe_o(a_nwe),
    .fl_nadv_o(a_nadv), .fl_nrst_o(a_nrst), .fl_addr_o(a_addr), .fl_dq_i(a_dq),
    .m_valid_o(a_valid), .m_data_o(a_data), .m_ready_i(ready));

  bflash_rdr #(.DATA_W(8), .ADDR_W(BW), .LEN_W(LW), .DUAL_DEV(1'b1), .LAT_CLKS(1)) dut_q_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(addr[BW-1:0]), .burst_len_i(len),
    .busy_o(b_busy), .fl_clk_o(b_fclk), .fl_nce_o(b_nce), .fl_noe_o(b_noe), .fl_nwe_o(b_nwe),
    .fl_nadv_o(b_nadv), .fl_nrst_o(b_nrst), .fl_addr_o(b_addr), .fl_dq_i(b_dq),
    .m_valid_o(b_valid), .m_data_o(b_data), .m_ready_i(ready));

  bflash_rdr_flash_model #(.DATA_W(16), .ADDR_W(AW), .LAT(3)) flash_a_i (
    .fclk(a_fclk), .nce(a_nce), .noe(a_noe), .nadv(a_nadv), .addr(a_addr),
    .dq(a_dq), .edge_idx(a_edge), .strobe_cnt(a_strobe));

  bflash_rdr_flash_model #(.DATA_W(8), .ADDR_W(BW), .LAT(1)) flash_b_i (
    .fclk(b_fclk), .nce(b_nce), .noe(b_noe), .nadv(b_nadv), .addr(b_addr),
    .dq(b_dq), .edge_idx(b_edge), .strobe_cnt(b_strobe));

  bflash_rdr_monitor #(.DATA_W(16), .ADDR_W(AW), .LEN_W(LW), .DIV(2), .LAT(3), .NAME("single")) mon_a (
    .clk(clk), .start(start), .addr(addr), .len(len), .busy(a_busy), .fclk(a_fclk),
    .nce(a_nce), .noe(a_noe), .nwe(a_nwe), .nadv(a_nadv), .m_valid(a_valid),
    .m_ready(ready), .m_data(a_data), .edge_idx(a_edge), .strobe_cnt(a_strobe));

  bflash_rdr_monitor #(.DATA_W(8), .ADDR_W(BW), .LEN_W(LW), .DIV(4), .LAT(1), .NAME("dual")) mon_b (
    .clk(clk), .start(start), .addr(addr[BW-1:0]), .len(len), .busy(b_busy), .fclk(b_fclk),
    .nce(b_nce), .noe(b_noe), .nwe(b_nwe), .nadv(b_nadv), .m_valid(b_valid),
    .m_ready(ready), .m_data(b_data), .edge_idx(b_edge), .strobe_cnt(b_strobe));

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    case (mode)
      1:       ready = cyc[0];
      2:       ready = !((cyc % 3) == 0 || (cyc % 7) == 1);
      default: ready = 1'b1;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    t_cmp++;
    if (!ok) begin
      t_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] a, input logic [LW-1:0] l);
    @(posedge clk); #1;
    addr = a; len = l; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!(mon_a.done && mon_b.done)) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             t_cmp + mon_a.n_cmp + mon_b.n_cmp + 1, t_bad + mon_a.n_bad + mon_b.n_bad + 1);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] addrs [3];
    int sa, sb;
    addrs[0] = 12'h000; addrs[1] = 12'h04D; addrs[2] = 12'hFFD;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(!a_nrst && !b_nrst, "R1 flash reset low in reset", {a_nrst, b_nrst}, 0);
    chk(a_nce && a_noe && a_nwe && a_nadv && !a_fclk && !a_valid && !a_busy,
        "R1 single idle pins in reset", {a_nce, a_noe, a_nwe, a_nadv, a_fclk, a_valid, a_busy}, 7'b1111000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release
    chk(a_nrst && b_nrst, "R1 flash reset released", {a_nrst, b_nrst}, 3);
    chk(a_nce && a_noe && a_nwe && a_nadv && !a_fclk && !a_valid && !a_busy,
        "R1 single idle pins", {a_nce, a_noe, a_nwe, a_nadv, a_fclk, a_valid, a_busy}, 7'b1111000);
    chk(b_nce && b_noe && b_nwe && b_nadv && !b_fclk && !b_valid && !b_busy,
        "R1 dual idle pins", {b_nce, b_noe, b_nwe, b_nadv, b_fclk, b_valid, b_busy}, 7'b1111000);

    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int ai = 0; ai < 3; ai++) begin
        for (int l = 1; l < 16; l++) begin
          pulse_start(addrs[ai], LW'(l));
          wait_done();
        end
      end
    end

    // R3: a second start during a running burst is refused
    mode = 2;
    pulse_start(12'h100, 4'd8);
    repeat (3) @(posedge clk); #1;
    addr = 12'h2A0; len = 4'd3; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done();
    @(negedge clk);
    chk(a_addr == 12'h100, "R3 start while busy ignored single", int'(a_addr), 'h100);
    chk(b_addr == 10'h100, "R3 start while busy ignored dual", int'(b_addr), 'h100);

    // R3: zero length is refused
    sa = a_strobe; sb = b_strobe;
    pulse_start(12'h300, 4'd0);
    repeat (12) @(negedge clk);
    chk(!a_busy && !b_busy && !a_valid && !b_valid, "R3 zero length stays idle",
        {a_busy, b_busy, a_valid, b_valid}, 0);
    chk(a_strobe == sa && b_strobe == sb, "R3 zero length no strobe", a_strobe + b_strobe, sa + sb);
    chk(a_addr == 12'h100, "R3 zero length address kept", int'(a_addr), 'h100);
    chk(!a_fclk && !b_fclk, "R2 clock low between bursts", {a_fclk, b_fclk}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             t_cmp + mon_a.n_cmp + mon_b.n_cmp, t_bad + mon_a.n_bad + mon_b.n_bad);
    $finish;
  end
endmodule